// File: doc/BRIEF.md
# Reset Cause Recorder with Software System Reset

This block keeps a sticky record of every reset event seen since the last power-on. Each incoming one-cycle event pulse (power-on, brown-out, external pin, clock-security failure, core voltage drop, system software reset, coprocessor system reset, two watchdogs, two standby wake-ups and two per-core resets) sets its own flag bit. The flags stay set until software clears them, so firmware clears the register after reading it and can then tell which cause came next.

A small register port exposes the flag register and a control register. Writing the control register requests a full system reset: the block drives a reset output for a fixed number of cycles and records the request as a software-reset flag. A combinational decoder reduces the flag set to one reported cause, picked by a fixed priority order, together with an instance number. The instance number tells apart sources of the same kind.

Top module: `rst_cause_flags`

## Requirements
- R1: After rst_ni is released, the flag register reads 0, sys_rst_o is low, the control register reads 0, and the decoded cause is unknown (code 0) with instance 0.
- R2: An event pulse on rst_evt_i bit b sets flag bit b at the next clock edge, for each used position: 0 power-on, 1 brown-out, 2 external pin, 3 clock-security failure, 4 core voltage, 6 system software reset, 7 coprocessor system reset, 8 watchdog 1, 9 watchdog 2, 11 standby, 12 coprocessor standby, 13 core 0, 14 core 1.
- R3: Flag bits 5, 10 and 15 and data bits 31:16 always read 0, and events on inputs 5, 10 and 15 have no effect. Reads of any address other than 0x404 and 0x408 return 0.
- R4: Flags are sticky: with no power-on event and no clear write, a set flag stays set, and new events accumulate alongside it.
- R5: The flag register is read at offset 0x408. A write there clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. An event arriving in the same cycle as its clear wins, and the flag stays set.
- R6: A power-on event leaves the flag register at exactly 0x0001, whatever else happens in that cycle.
- R7: A write to offset 0x404 with data bit 0 set, while no request is active, drives sys_rst_o high from the next cycle for exactly PULSE_LEN cycles. It sets flag bit 6, and bit 0 of offset 0x404 reads 1 while the pulse is active and 0 after it ends.
- R8: A write to offset 0x404 with data bit 0 clear, or any write there while a pulse is already active, does not start or lengthen a pulse.
- R9: The decoded cause is taken from the first set flag in this order: 0, 1, 11, 12, 6, 13, 14, 8, 9, 2.
- R10: Cause codes on cause_o are 1 power-on, 2 brown-out, 3 wake-up, 4 reset, 5 watchdog, 6 external pin. Instances are: standby 0 and coprocessor standby 1 (wake-up); core 0 is 0, core 1 is 1 and system software reset is 2 (reset); watchdog 1 is 0 and watchdog 2 is 1; external pin is 1; power-on and brown-out are 0.
- R11: When no flag in the priority list is set (including when only bits 3, 4 or 7 are set), cause_o is 0 (unknown) and cause_inst_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_evt_i | input | 16 | One-cycle reset event pulses, one per flag position |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from address |
| sys_rst_o | output | 1 | Software-requested system reset pulse |
| cause_o | output | 3 | Decoded highest-priority reset cause code |
| cause_inst_o | output | 2 | Instance number of the decoded cause |

## Verification
The assertions check on every cycle that reserved flags stay zero and that each event sets its flag one edge later. They also check that flags only fall on a clear write or a power-on, that a power-on leaves exactly bit 0, that each reset pulse lasts exactly PULSE_LEN cycles and is marked in bit 6, and that the decode reports power-on whenever bit 0 is set and unknown on an empty register. Only the bench scenarios show the full priority order between mixed flag sets, the per-source instance numbers, the clear-versus-event race, and that writes with bit 0 low or during an active pulse are ignored. They do this by running a behavioural model beside the design every clock.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int unsigned FLAG_W     = 16;
  localparam int unsigned IDX_W      = $clog2(FLAG_W);
  localparam logic [FLAG_W-1:0] VALID_MASK = 16'h7BDF;
  localparam int unsigned BIT_POR    = 0;
  localparam int unsigned BIT_SWRST  = 6;
  localparam int unsigned NUM_PRIO   = 10;

  typedef enum logic [2:0] {
    CAUSE_UNKNOWN   = 3'd0,
    CAUSE_POWER_ON  = 3'd1,
    CAUSE_BROWN_OUT = 3'd2,
    CAUSE_WAKEUP    = 3'd3,
    CAUSE_RESET     = 3'd4,
    CAUSE_WATCHDOG  = 3'd5,
    CAUSE_EXT_PIN   = 3'd6
  } cause_e;

  // index 0 is the highest priority
  localparam logic [IDX_W-1:0] PRIO_BIT [NUM_PRIO] = '{
    4'd0, 4'd1, 4'd11, 4'd12, 4'd6, 4'd13, 4'd14, 4'd8, 4'd9, 4'd2};
  localparam cause_e PRIO_CAUSE [NUM_PRIO] = '{
    CAUSE_POWER_ON, CAUSE_BROWN_OUT, CAUSE_WAKEUP, CAUSE_WAKEUP, CAUSE_RESET,
    CAUSE_RESET, CAUSE_RESET, CAUSE_WATCHDOG, CAUSE_WATCHDOG, CAUSE_EXT_PIN};
  localparam logic [1:0] PRIO_INST [NUM_PRIO] = '{
    2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd1, 2'd1};
endpackage

// File: rtl/rcf_flag_bank.sv
module rcf_flag_bank
  import rcf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic [FLAG_W-1:0] clr_mask_i,
  input  logic              sw_set_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^((evt_i | clr_mask_i) & ~VALID_MASK);

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (VALID_MASK[b]) begin : g_used
      logic set_now;
      assign set_now = evt_i[b] | (sw_set_i & (b == BIT_SWRST));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       flags_o[b] <= 1'b0;
        else if (evt_i[BIT_POR])           flags_o[b] <= (b == BIT_POR);
        else if (set_now)                  flags_o[b] <= 1'b1;
        else if (clr_we_i && clr_mask_i[b]) flags_o[b] <= 1'b0;
      end
    end else begin : g_rsvd
      assign flags_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/rcf_soft_reset.sv
module rcf_soft_reset #(
  parameter int unsigned PULSE_LEN = 8,
  localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic active_o
);
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = req_i & ~active_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (active_o) begin
      if (cnt_q == '0) active_o <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end else if (accept_o) begin
      active_o <= 1'b1;
      cnt_q    <= CNT_W'(PULSE_LEN - 1);
    end
  end
endmodule

// File: rtl/rcf_cause_decode.sv
module rcf_cause_decode
  import rcf_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  output cause_e            cause_o,
  output logic [1:0]        inst_o
);
  always_comb begin
    cause_o = CAUSE_UNKNOWN;
    inst_o  = 2'd0;
    // walk from lowest priority up so the highest set entry wins
    for (int i = NUM_PRIO - 1; i >= 0; i--) begin
      if (flags_i[PRIO_BIT[i]]) begin
        cause_o = PRIO_CAUSE[i];
        inst_o  = PRIO_INST[i];
      end
    end
  end
endmodule

// File: rtl/rst_cause_flags.sv
module rst_cause_flags
  import rcf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PULSE_LEN = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h404,
  parameter logic [ADDR_W-1:0] FLAG_OFF = 'h408
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] rst_evt_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sys_rst_o,
  output logic [2:0]        cause_o,
  output logic [1:0]        cause_inst_o
);
  logic [FLAG_W-1:0] flags;
  logic              clr_we, req, sw_accept, sw_active;
  cause_e            cause;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:FLAG_W];
  assign clr_we = reg_we_i && (reg_addr_i == FLAG_OFF);
  assign req    = reg_we_i && (reg_addr_i == CTRL_OFF) && reg_wdata_i[0];

  rcf_flag_bank u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (rst_evt_i),
    .clr_we_i   (clr_we),
    .clr_mask_i (reg_wdata_i[FLAG_W-1:0]),
    .sw_set_i   (sw_accept),
    .flags_o    (flags)
  );

  rcf_soft_reset #(.PULSE_LEN(PULSE_LEN)) u_swrst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .accept_o (sw_accept),
    .active_o (sw_active)
  );

  rcf_cause_decode u_dec (
    .flags_i (flags),
    .cause_o (cause),
    .inst_o  (cause_inst_o)
  );

  assign cause_o   = cause;
  assign sys_rst_o = sw_active;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == FLAG_OFF)      reg_rdata_o[FLAG_W-1:0] = flags;
    else if (reg_addr_i == CTRL_OFF) reg_rdata_o[0]          = sw_active;
  end
endmodule

// File: rtl/rst_cause_flags_chk.sv
module rst_cause_flags_chk
  import rcf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PULSE_LEN = 8,
  parameter logic [ADDR_W-1:0] FLAG_OFF = 'h408
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FLAG_W-1:0] rst_evt_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic              sys_rst_o,
  input logic [2:0]        cause_o,
  input logic [1:0]        cause_inst_o,
  input logic [FLAG_W-1:0] flags_i
);
  int unsigned hi_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run <= 0;
    else if (sys_rst_o) hi_run <= hi_run + 1;
    else                hi_run <= 0;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i & ~VALID_MASK) == '0); // R3
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_evt_i[BIT_POR] |=>
      ((flags_i & $past(rst_evt_i & VALID_MASK)) == $past(rst_evt_i & VALID_MASK))); // R2
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_evt_i[BIT_POR] && !(reg_we_i && reg_addr_i == FLAG_OFF)) |=>
      ((flags_i & $past(flags_i)) == $past(flags_i))); // R4
  AST_POR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt_i[BIT_POR] |=> (flags_i == FLAG_W'(1))); // R6
  AST_SW_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_o) && !$past(rst_evt_i[BIT_POR])) |-> flags_i[BIT_SWRST]); // R7
  AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (hi_run < PULSE_LEN)); // R7
  AST_PULSE_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (hi_run == PULSE_LEN)); // R7
  AST_POR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i[BIT_POR] |-> (cause_o == CAUSE_POWER_ON && cause_inst_o == 2'd0)); // R9
  AST_EMPTY_UNKNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i == '0) |-> (cause_o == CAUSE_UNKNOWN && cause_inst_o == 2'd0)); // R11
endmodule

bind rst_cause_flags rst_cause_flags_chk #(
  .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN), .FLAG_OFF(FLAG_OFF)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_evt_i    (rst_evt_i),
  .reg_addr_i   (reg_addr_i),
  .reg_we_i     (reg_we_i),
  .sys_rst_o    (sys_rst_o),
  .cause_o      (cause_o),
  .cause_inst_o (cause_inst_o),
  .flags_i      (flags)
);

// File: tb/tb_rst_cause_flags.sv
`timescale 1ns/1ps
module tb_rst_cause_flags;
  localparam int PULSE = 8;
  localparam logic [11:0] A_CTRL = 12'h404;
  localparam logic [11:0] A_FLAG = 12'h408;
  localparam logic [15:0] USED = 16'h0001 | 16'h0002 | 16'h0004 | 16'h0008 | 16'h0010 |
    16'h0040 | 16'h0080 | 16'h0100 | 16'h0200 | 16'h0800 | 16'h1000 | 16'h2000 | 16'h4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic [11:0] addr = A_FLAG;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sys_rst;
  logic [2:0] cause;
  logic [1:0] inst;

  int checks = 0, failures = 0;
  string cur = "R1";

  always #2 clk = ~clk;

  rst_cause_flags #(.PULSE_LEN(PULSE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_evt_i(evt), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sys_rst_o(sys_rst), .cause_o(cause), .cause_inst_o(inst));

  // behavioural reference
  logic [15:0] m_flags;
  bit m_req;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0; m_req = 0; m_cnt = 0;
    end else begin
      bit acc;
      logic [15:0] nf;
      acc = we && addr == A_CTRL && wdata[0] && !m_req;
      nf = m_flags;
      if (we && addr == A_FLAG) nf = nf & ~wdata[15:0];
      nf = nf | (evt & USED);
      if (acc) nf[6] = 1'b1;
      if (evt[0]) nf = 16'h0001;
      if (m_req) begin
        m_cnt--;
        if (m_cnt == 0) m_req = 0;
      end else if (acc) begin
        m_req = 1; m_cnt = PULSE;
      end
      m_flags = nf;
    end
  end

  function automatic logic [4:0] exp_dec(logic [15:0] f);
    if (f[0])  return {3'd1, 2'd0};
    if (f[1])  return {3'd2, 2'd0};
    if (f[11]) return {3'd3, 2'd0};
    if (f[12]) return {3'd3, 2'd1};
    if (f[6])  return {3'd4, 2'd2};
    if (f[13]) return {3'd4, 2'd0};
    if (f[14]) return {3'd4, 2'd1};
    if (f[8])  return {3'd5, 2'd0};
    if (f[9])  return {3'd5, 2'd1};
    if (f[2])  return {3'd6, 2'd1};
    return 5'd0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    if (a == A_FLAG) return {16'h0, m_flags};
    if (a == A_CTRL) return {31'h0, m_req};
    return 32'h0;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("rdata", rdata, exp_rd(addr));
    chk("sys_rst", {31'h0, sys_rst}, {31'h0, m_req});
    chk("cause", {29'h0, cause}, {29'h0, exp_dec(m_flags)[4:2]});
    chk("inst", {30'h0, inst}, {30'h0, exp_dec(m_flags)[1:0]});
  end

  task automatic drive(logic [15:0] e, logic w, logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    evt = e; we = w; addr = a; wdata = d;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive('0, 1'b0, A_FLAG, '0);
  endtask
  task automatic pulse(int b);
    drive(16'(1) << b, 1'b0, A_FLAG, '0);
  endtask
  task automatic clear_all();
    drive('0, 1'b1, A_FLAG, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cur = "R1"; idle(2);
    drive('0, 1'b0, A_CTRL, '0);
    idle(1);

    cur = "R2";
    for (int b = 1; b < 15; b++) begin
      pulse(b); idle(1); clear_all(); idle(1);
    end

    cur = "R3";
    pulse(5); pulse(10); pulse(15); idle(1);
    drive('0, 1'b0, 12'h400, '0);
    drive('0, 1'b0, 12'h40C, '0);
    idle(1);

    cur = "R4";
    pulse(8); pulse(2); pulse(13); idle(3);
    drive(16'h0090, 1'b0, A_FLAG, '0); idle(2);

    cur = "R5";
    drive('0, 1'b1, A_FLAG, 32'h0000_0100); idle(1);
    drive('0, 1'b1, A_FLAG, 32'h0000_0000); idle(1);
    drive(16'h0004, 1'b1, A_FLAG, 32'h0000_2004); idle(2);

    cur = "R6";
    pulse(9); pulse(11); idle(1);
    drive(16'h0201, 1'b1, A_CTRL, 32'h1); idle(PULSE + 2);
    pulse(0); idle(1);
    clear_all(); idle(1);

    cur = "R7";
    drive('0, 1'b1, A_CTRL, 32'h1);
    for (int i = 0; i < PULSE + 3; i++) drive('0, 1'b0, (i % 2) ? A_FLAG : A_CTRL, '0);
    clear_all(); idle(1);

    cur = "R8";
    drive('0, 1'b1, A_CTRL, 32'hFFFF_FFFE); idle(3);
    drive('0, 1'b1, A_CTRL, 32'h1); idle(3);
    drive('0, 1'b1, A_CTRL, 32'h1); idle(2);
    drive('0, 1'b1, A_CTRL, 32'h1);
    for (int i = 0; i < PULSE + 3; i++) drive('0, 1'b0, A_CTRL, '0);
    clear_all(); idle(1);

    cur = "R9";
    drive(16'h0204, 1'b0, A_FLAG, '0); idle(1); clear_all();
    drive(16'h4100, 1'b0, A_FLAG, '0); idle(1); clear_all();
    drive(16'h2040, 1'b0, A_FLAG, '0); idle(1); clear_all();
    drive(16'h1040, 1'b0, A_FLAG, '0); idle(1); clear_all();
    drive(16'h1800, 1'b0, A_FLAG, '0); idle(1); clear_all();
    drive(16'h0802, 1'b0, A_FLAG, '0); idle(1); clear_all();
    drive(16'h6000, 1'b0, A_FLAG, '0); idle(1); clear_all();
    drive(16'h0300, 1'b0, A_FLAG, '0); idle(1);
    drive('0, 1'b1, A_FLAG, 32'h0100); idle(1); clear_all(); idle(1);

    cur = "R10";
    for (int b = 0; b < 15; b++) begin
      pulse(b); idle(1); clear_all(); idle(1);
    end

    cur = "R11";
    pulse(3); pulse(4); pulse(7); idle(2);
    clear_all(); idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL %s watchdog actual=hung expected=done", cur);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule